// File: doc/BRIEF.md
# Transmit Stream Protocol Guard

This block sits on the transmit stream between an application and an Ethernet MAC. The stream carries a data word, a per-byte keep mask, a last marker, valid/ready handshaking, and a two-bit user field. Bit 1 of the user field selects CRC-skip mode: no CRC, no pad and no source address insertion by the MAC. Bit 0 of the user field requests error injection. The guard forwards every signal straight through with no added latency. It watches each cycle for breaches of the stricter rules the MAC depends on.

It enforces four rules. Inside a packet, valid must not drop while the MAC is ready. Null bytes may appear only on the last beat. The CRC-skip bit must hold one value for the whole packet. A beat flagged as a one-step timing packet must not set CRC-skip. A breach raises a sticky flag, and the flag stays set until the clear input is pulsed. A pulse at the accepted last beat reports that the packet broke at least one rule. When an underflow occurs, the packet's last beat leaves with the error-injection bit forced high, so the MAC corrupts that frame.

Top module: `txs_proto_guard`

## Requirements
- R1: Data, keep, last and valid, and user bit 1, reach the MAC side unchanged in the same cycle. The application-side ready equals the MAC-side ready.
- R2: An underflow is valid low with MAC ready high while a packet is open. `underflow_o` is high in that cycle, and flag bit 0 is set from the next cycle.
- R3: A packet that underflowed leaves with output user bit 0 high on its last beat, whatever the application drove on bit 0.
- R4: Keep has one bit per byte, with 1 meaning a valid byte. An accepted beat without last must have keep all ones. An accepted last beat must have keep nonzero, with its ones forming one run starting at byte 0. A breach sets flag bit 1.
- R5: On accepted beats after the first, user bit 1 must match its value on the packet's first beat. A mismatch sets flag bit 2.
- R6: An accepted beat with the one-step timing mark high and user bit 1 high sets flag bit 3.
- R7: User bit 0 is forwarded only on beats with last high. On other beats, output user bit 0 is low and no flag is raised.
- R8: `pkt_viol_o` pulses for one cycle on the accepted last beat of a packet that broke any rule, including a breach on that same beat. It is low at all other times.
- R9: Flags stay set until `clr_i` is high at a clock edge. An event in the same cycle as the clear leaves its flag set.
- R10: An active-low asynchronous reset clears the flags and the open-packet state. With no packet open, valid low with ready high is not an underflow.
- R11: A packet opens on its first beat accepted with valid and ready both high, and closes on the accepted last beat. Cycles with ready low never count as underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Clears the sticky flags |
| tx_in_valid | input | 1 | Application valid |
| tx_in_ready | output | 1 | Ready back to the application |
| tx_in_data | input | DATA_W | Application data |
| tx_in_keep | input | DATA_W/8 | Byte keep mask |
| tx_in_last | input | 1 | Last beat of the packet |
| tx_in_user | input | 2 | Bit 1 CRC-skip, bit 0 error injection |
| tx_in_onestep | input | 1 | Beat belongs to a one-step timing packet |
| tx_out_valid | output | 1 | Valid to the MAC |
| tx_out_ready | input | 1 | Ready from the MAC |
| tx_out_data | output | DATA_W | Data to the MAC |
| tx_out_keep | output | DATA_W/8 | Keep to the MAC |
| tx_out_last | output | 1 | Last to the MAC |
| tx_out_user | output | 2 | User field to the MAC, bit 0 marked on underflow |
| flags_o | output | 4 | Sticky flags: 0 underflow, 1 keep, 2 CRC-skip change, 3 one-step with CRC-skip |
| pkt_viol_o | output | 1 | Packet-breach pulse at the accepted last beat |
| underflow_o | output | 1 | Underflow in the current cycle |

## Verification
Clean multi-beat and single-beat packets with partial last-beat masks establish that nothing is flagged when the rules are kept. Gaps with ready low, stalls with valid high, and idle cycles between packets separate true underflows from harmless pauses. Masks with holes, an empty last mask, and a short mask on a middle beat distinguish the three keep cases from each other. CRC-skip changes, one-step beats, error-injection requests on middle and last beats, and a clear that coincides with an event each test one flag or the marking path in isolation.

// File: rtl/txg_pkg.sv
package txg_pkg;
  localparam int unsigned NFLAG  = 4;
  localparam int unsigned F_UFL  = 0;
  localparam int unsigned F_KEEP = 1;
  localparam int unsigned F_CRC  = 2;
  localparam int unsigned F_PTP  = 3;
  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/txg_rst_sync.sv
module txg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/txg_keep_check.sv
module txg_keep_check #(
  parameter int unsigned KEEP_W = 8
) (
  input  logic              acc,
  input  logic              last,
  input  logic [KEEP_W-1:0] keep,
  output logic              bad
);
  logic [KEEP_W-1:0] zero_below;
  logic              hole;
  logic              tail_ok;

  assign zero_below[0] = 1'b0;
  for (genvar i = 1; i < KEEP_W; i++) begin : g_chain
    assign zero_below[i] = zero_below[i-1] | ~keep[i-1];
  end

  assign hole    = |(keep & zero_below);
  assign tail_ok = keep[0] & ~hole;

  always_comb begin
    bad = 1'b0;
    if (acc) begin
      if (last) bad = ~tail_ok;
      else      bad = ~(&keep);
    end
  end
endmodule

// File: rtl/txg_pkt_track.sv
module txg_pkt_track (
  input  logic clk,
  input  logic rst_n,
  input  logic acc,
  input  logic last,
  input  logic crc_bit,
  input  logic uf,
  input  logic beat_ev,
  output logic in_pkt,
  output logic crc_hold,
  output logic pkt_uf,
  output logic pkt_any
);
  logic in_pkt_d, crc_hold_d, pkt_uf_d, pkt_any_d;
  logic close;

  assign close = acc & last;

  always_comb begin
    in_pkt_d   = in_pkt;
    crc_hold_d = crc_hold;
    pkt_uf_d   = pkt_uf | uf;
    pkt_any_d  = pkt_any | beat_ev;
    if (acc) begin
      if (!in_pkt) crc_hold_d = crc_bit;
      in_pkt_d = ~last;
    end
    if (close) begin
      pkt_uf_d  = 1'b0;
      pkt_any_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt   <= 1'b0;
      crc_hold <= 1'b0;
      pkt_uf   <= 1'b0;
      pkt_any  <= 1'b0;
    end else begin
      in_pkt   <= in_pkt_d;
      crc_hold <= crc_hold_d;
      pkt_uf   <= pkt_uf_d;
      pkt_any  <= pkt_any_d;
    end
  end

  p_close_r11: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> !in_pkt);
  p_open_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !last) |=> in_pkt);
  p_uf_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && !close) |=> pkt_uf);
endmodule

// File: rtl/txg_flag_bank.sv
module txg_flag_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] ev,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic d;
    always_comb d = (q[i] & ~clr) | ev[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= d;
    end

    p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ev[i] |=> q[i]);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (q[i] && !clr) |=> q[i]);
    p_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q[i]) |-> $past(ev[i]));
  end
endmodule

// File: rtl/txs_proto_guard.sv
module txs_proto_guard
  import txg_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  tx_in_valid,
  output logic                  tx_in_ready,
  input  logic [DATA_W-1:0]     tx_in_data,
  input  logic [DATA_W/8-1:0]   tx_in_keep,
  input  logic                  tx_in_last,
  input  logic [1:0]            tx_in_user,
  input  logic                  tx_in_onestep,
  output logic                  tx_out_valid,
  input  logic                  tx_out_ready,
  output logic [DATA_W-1:0]     tx_out_data,
  output logic [DATA_W/8-1:0]   tx_out_keep,
  output logic                  tx_out_last,
  output logic [1:0]            tx_out_user,
  output logic [NFLAG-1:0]      flags_o,
  output logic                  pkt_viol_o,
  output logic                  underflow_o
);
  localparam int unsigned KEEP_W = DATA_W / 8;

  logic      rst_q;
  logic      acc, uf, keep_bad, crc_bad, ptp_bad;
  logic      in_pkt, crc_hold, pkt_uf, pkt_any;
  flag_vec_t ev;

  txg_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_q));

  assign acc = tx_in_valid & tx_out_ready;
  assign uf  = in_pkt & ~tx_in_valid & tx_out_ready;

  txg_keep_check #(.KEEP_W(KEEP_W)) u_keep (
    .acc(acc), .last(tx_in_last), .keep(tx_in_keep), .bad(keep_bad)
  );

  assign crc_bad = acc & in_pkt & (tx_in_user[1] != crc_hold);
  assign ptp_bad = acc & tx_in_onestep & tx_in_user[1];

  always_comb begin
    ev         = '0;
    ev[F_UFL]  = uf;
    ev[F_KEEP] = keep_bad;
    ev[F_CRC]  = crc_bad;
    ev[F_PTP]  = ptp_bad;
  end

  txg_pkt_track u_track (
    .clk(clk), .rst_n(rst_q), .acc(acc), .last(tx_in_last),
    .crc_bit(tx_in_user[1]), .uf(uf), .beat_ev(|ev),
    .in_pkt(in_pkt), .crc_hold(crc_hold), .pkt_uf(pkt_uf), .pkt_any(pkt_any)
  );

  txg_flag_bank #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_q), .clr(clr_i), .ev(ev), .q(flags_o)
  );

  assign tx_in_ready  = tx_out_ready;
  assign tx_out_valid = tx_in_valid;
  assign tx_out_data  = tx_in_data;
  assign tx_out_keep  = tx_in_keep;
  assign tx_out_last  = tx_in_last;
  assign tx_out_user  = {tx_in_user[1], tx_in_last & (tx_in_user[0] | pkt_uf)};
  assign pkt_viol_o   = acc & tx_in_last & (pkt_any | (|ev));
  assign underflow_o  = uf;

  p_pulse_last_r8: assert property (@(posedge clk) disable iff (!rst_q)
    pkt_viol_o |-> (tx_in_valid && tx_out_ready && tx_in_last));
  p_mark_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (pkt_uf && tx_in_last) |-> tx_out_user[0]);
  p_inj_mid_r7: assert property (@(posedge clk) disable iff (!rst_q)
    !tx_in_last |-> !tx_out_user[0]);
  p_no_uf_stall_r11: assert property (@(posedge clk) disable iff (!rst_q)
    !tx_out_ready |-> !underflow_o);
  p_uf_flag_r2: assert property (@(posedge clk) disable iff (!rst_q)
    underflow_o |=> flags_o[F_UFL]);
endmodule

// File: tb/txs_proto_guard_tb.sv
module txs_proto_guard_tb;
  localparam int DW = 64;
  localparam int KW = DW / 8;

  logic clk = 1'b0;
  logic rst_n, clr;
  logic iv, ir, il, ios, ov, ol, pv, uo;
  logic [DW-1:0] id, od;
  logic [KW-1:0] ik, ok;
  logic [1:0] iu, ou;
  logic [3:0] fl;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  int m_inpkt = 0, m_crch = 0, m_pktuf = 0, m_pktany = 0;
  logic [3:0] m_sticky = 4'h0;
  logic [63:0] dcount = 64'h0123_4567_89ab_cdef;

  always #2 clk = ~clk;

  txs_proto_guard #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr),
    .tx_in_valid(iv), .tx_in_ready(ir), .tx_in_data(id), .tx_in_keep(ik),
    .tx_in_last(il), .tx_in_user(iu), .tx_in_onestep(ios),
    .tx_out_valid(ov), .tx_out_ready(ir_m), .tx_out_data(od),
    .tx_out_keep(ok), .tx_out_last(ol), .tx_out_user(ou),
    .flags_o(fl), .pkt_viol_o(pv), .underflow_o(uo)
  );
  logic ir_m;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit keep_ok(input logic [KW-1:0] k, input bit last);
    bit seen_zero = 0;
    if (!last) return (k == {KW{1'b1}});
    if (k[0] == 1'b0) return 0;
    for (int b = 0; b < KW; b++) begin
      if (!k[b]) seen_zero = 1;
      else if (seen_zero) return 0;
    end
    return 1;
  endfunction

  task automatic beat(input bit v, input bit r, input bit l, input logic [KW-1:0] k,
                      input logic [1:0] u, input bit os, input bit c);
    bit a, e_uf, e_keep, e_crc, e_ptp, e_pulse;
    logic [3:0] ev;
    iv = v; ir_m = r; il = l; ik = k; iu = u; ios = os; clr = c;
    dcount = {dcount[62:0], dcount[63] ^ dcount[60]} + 64'd7;
    id = dcount;
    #1;
    a      = v && r;
    e_uf   = m_inpkt != 0 && !v && r;
    e_keep = a && !keep_ok(k, l);
    e_crc  = a && m_inpkt != 0 && (int'(u[1]) != m_crch);
    e_ptp  = a && os && u[1];
    ev     = {e_ptp, e_crc, e_keep, e_uf};
    e_pulse = a && l && (m_pktany != 0 || ev != 0);
    // R1 pass-through
    chk("R1 data", od, id);
    chk("R1 keep/last/valid/ready", {ok, ol, ov, ir}, {k, l, v, r});
    chk("R1 user1", ou[1], u[1]);
    // R3 / R7 output user bit 0
    chk("R3/R7 user0", ou[0], l && (u[0] || m_pktuf != 0));
    // R2 / R11 underflow now
    chk("R2/R11 underflow", uo, e_uf);
    // R8 packet pulse
    chk("R8 pulse", pv, e_pulse);
    // R4 R5 R6 R9 sticky flags
    chk("R4/R5/R6/R9 flags", fl, m_sticky);
    @(posedge clk);
    m_sticky = (c ? 4'h0 : m_sticky) | ev;
    if (e_uf) m_pktuf = 1;
    if (ev != 0) m_pktany = 1;
    if (a) begin
      if (m_inpkt == 0) m_crch = u[1];
      m_inpkt = l ? 0 : 1;
      if (l) begin m_pktuf = 0; m_pktany = 0; end
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) beat(0, 1, 0, '1, 2'b00, 0, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; iv = 0; ir_m = 1; il = 0; ik = '1; iu = 0; ios = 0; clr = 0; id = '0;
    repeat (3) @(negedge clk);
    chk("R10 flags in reset", fl, 4'h0);
    chk("R10 pulse in reset", {pv, uo}, 2'b00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_inpkt = 0; m_pktuf = 0; m_pktany = 0; m_sticky = 0; m_crch = 0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R10: idle with ready high and no open packet
    idle(3);
    // clean packet with partial last mask
    beat(1, 1, 0, '1, 2'b00, 0, 0);
    beat(1, 1, 0, '1, 2'b00, 0, 0);
    beat(1, 1, 1, 8'h0F, 2'b00, 0, 0);
    // R11: ready-low gaps and stalls are harmless
    beat(1, 1, 0, '1, 2'b10, 0, 0);
    beat(0, 0, 0, '1, 2'b10, 0, 0);
    beat(1, 0, 0, '1, 2'b10, 0, 0);
    beat(1, 1, 0, '1, 2'b10, 0, 0);
    beat(1, 1, 1, 8'h01, 2'b10, 0, 0);
    idle(2);
    // R2 R3 underflow then last beat marked
    beat(1, 1, 0, '1, 2'b00, 0, 0);
    beat(0, 1, 0, '1, 2'b00, 0, 0);
    beat(1, 1, 0, '1, 2'b00, 0, 0);
    beat(1, 1, 1, '1, 2'b00, 0, 0);
    beat(0, 1, 0, '1, 2'b00, 0, 1);
    // R4 short mask mid packet, hole on last
    beat(1, 1, 0, 8'h7F, 2'b00, 0, 0);
    beat(1, 1, 1, 8'h0D, 2'b00, 0, 0);
    beat(1, 1, 1, 8'h00, 2'b00, 0, 1);
    beat(1, 1, 1, 8'hFE, 2'b00, 0, 1);
    idle(1);
    beat(0, 1, 0, '1, 2'b00, 0, 1);
    // R5 CRC-skip change inside a packet
    beat(1, 1, 0, '1, 2'b00, 0, 0);
    beat(1, 1, 0, '1, 2'b10, 0, 0);
    beat(1, 1, 1, '1, 2'b10, 0, 0);
    beat(0, 1, 0, '1, 2'b00, 0, 1);
    // R6 one-step with CRC-skip, and one-step without
    beat(1, 1, 1, '1, 2'b00, 1, 0);
    beat(1, 1, 1, '1, 2'b10, 1, 0);
    beat(0, 1, 0, '1, 2'b00, 0, 1);
    // R7 error injection mid packet ignored, on last forwarded
    beat(1, 1, 0, '1, 2'b01, 0, 0);
    beat(1, 1, 0, '1, 2'b01, 0, 0);
    beat(1, 1, 1, 8'h3F, 2'b01, 0, 0);
    // R9 clear in the same cycle as an event
    beat(1, 1, 0, '1, 2'b00, 0, 0);
    beat(0, 1, 0, '1, 2'b00, 0, 1);
    beat(1, 1, 1, '1, 2'b00, 0, 0);
    beat(0, 1, 0, '1, 2'b00, 0, 0);
    beat(0, 1, 0, '1, 2'b00, 0, 1);
    idle(2);
    // R10 reset in the middle of an open packet
    beat(1, 1, 0, '1, 2'b00, 0, 0);
    beat(1, 1, 0, 8'h03, 2'b00, 0, 0);
    do_reset();
    idle(3);
    beat(1, 1, 1, 8'h07, 2'b10, 0, 0);
    idle(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule